// File: doc/BRIEF.md
# Weighted Multiport Burst Arbiter

This block sits in front of a single DRAM controller command input and shares it among several local request ports. Each port hands over one transaction at a time: a direction (read or write), a start address and a length counted in DRAM bursts. The block keeps the transaction and cuts it into single-burst commands. Every burst then competes for the command output on its own, so a long transaction on one port does not block a short one on another.

Selection works in two stages. A port at a higher absolute priority level always beats any port at a lower level. Among the ports that share the top level, a deficit round robin shares the bursts in proportion to per-port weights. Levels and weights are live inputs and may change at any time. The block issues one burst command at a time over a valid/ready handshake and holds it unchanged until it is accepted. It does not carry data, does not reorder bursts for row locality and does not model DRAM timing.

Top module: `burst_arbiter`

## Requirements
- R1: After reset `cmd_valid` is 0 and every bit of `req_ready` is 1.
- R2: `req_ready[i]` is 1 only while port i holds no transaction. A transaction is taken on a cycle where `req_valid[i]` and `req_ready[i]` are both high. From the next cycle until the final burst of that transaction is accepted, `req_ready[i]` is 0.
- R3: A transaction with length L issues L burst commands, and a length of 0 issues one. The first command carries the start address, and each later command adds `BURST_BYTES` to it. `cmd_write` repeats the transaction's direction, and `cmd_last` is 1 only on the final burst.
- R4: Priority is a 2-bit field per port (`cfg_prio[2*i+1:2*i]`), and 3 is the highest level. No grant goes to a port while a port with a higher level holds a transaction.
- R5: Weight is a 4-bit field per port (`cfg_weight[4*i+3:4*i]`), and 0 counts as 1. Within the top level a round-robin pointer moves over the pending ports. When the port it selects has no credit left, the port's weight is added to its deficit. Each accepted burst removes one unit of credit, and the pointer moves on once the credit reaches zero or the transaction ends. With weights 3 and 1 and long transactions, the grants repeat the pattern 3:1.
- R6: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_port`, `cmd_addr`, `cmd_write` and `cmd_last` hold their values.
- R7: A change to a level or a weight takes effect at the next grant decision. A grant that was already presented is not withdrawn.
- R8: When its transaction ends, a port's deficit is cleared, so a new transaction starts with no banked credit.
- R9: Each accepted handshake carries exactly one burst. `cmd_valid` is 0 in the cycle after an acceptance, and a new grant is decided in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | PORTS | Per-port transaction offer |
| req_ready | output | PORTS | Per-port idle, transaction can be taken |
| req_write | input | PORTS | Per-port direction, 1 = write |
| req_addr | input | PORTS*ADDR_W | Per-port start address, port i at bits [ADDR_W*i +: ADDR_W] |
| req_len | input | PORTS*LEN_W | Per-port length in bursts, 0 means 1 |
| cfg_prio | input | PORTS*PRIO_W | Per-port absolute priority level |
| cfg_weight | input | PORTS*WT_W | Per-port round-robin weight |
| cmd_valid | output | 1 | Burst command presented |
| cmd_ready | input | 1 | Controller accepts the burst command |
| cmd_port | output | PW | Port that owns the presented burst |
| cmd_write | output | 1 | Direction of the presented burst |
| cmd_addr | output | ADDR_W | Address of the presented burst |
| cmd_last | output | 1 | Presented burst ends its transaction |

## Verification
Two things can happen in the same cycle. The final burst of one port's transaction can be accepted, which frees that port, clears its deficit and moves the pointer. At the same edge another port can load a new transaction, or a level or weight can be rewritten. The bench provokes this with a random mix of offers, configuration writes and a `cmd_ready` that stalls at random. A behavioural model with its own counters predicts every output and is compared on every clock. Directed phases also check the 3:1 weighted share, strict-level blocking and a mid-stream level change.

// File: rtl/burst_arbiter.sv
module burst_arbiter #(
  parameter int PORTS       = 6,
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 8,
  parameter int BURST_BYTES = 32,
  parameter int PRIO_W      = 2,
  parameter int WT_W        = 4,
  localparam int PW         = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PORTS-1:0]          req_valid,
  output logic [PORTS-1:0]          req_ready,
  input  logic [PORTS-1:0]          req_write,
  input  logic [PORTS*ADDR_W-1:0]   req_addr,
  input  logic [PORTS*LEN_W-1:0]    req_len,
  input  logic [PORTS*PRIO_W-1:0]   cfg_prio,
  input  logic [PORTS*WT_W-1:0]     cfg_weight,
  output logic                      cmd_valid,
  input  logic                      cmd_ready,
  output logic [PW-1:0]             cmd_port,
  output logic                      cmd_write,
  output logic [ADDR_W-1:0]         cmd_addr,
  output logic                      cmd_last
);
  localparam int DEF_W = WT_W + 2;

  logic [PORTS-1:0]        busy;
  logic [PORTS-1:0]        wr;
  logic [LEN_W-1:0]        rem  [PORTS];
  logic [ADDR_W-1:0]       addr [PORTS];
  logic signed [DEF_W-1:0] dfc  [PORTS];
  logic [PW-1:0]           ptr;

  logic [PRIO_W-1:0] top;
  logic              found;
  logic [PW-1:0]     win;
  logic [WT_W-1:0]   w_raw;
  logic [WT_W-1:0]   w_eff;
  logic              take;
  logic              done;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (int'(p) == PORTS - 1) ? '0 : p + 1'b1;
  endfunction

  assign req_ready = ~busy;
  assign take      = !cmd_valid && found;
  assign done      = cmd_valid && cmd_ready;
  assign w_raw     = cfg_weight[int'(win)*WT_W +: WT_W];
  assign w_eff     = (w_raw == '0) ? WT_W'(1) : w_raw;

  always_comb begin
    top   = '0;
    found = 1'b0;
    win   = '0;
    for (int i = 0; i < PORTS; i++)
      if (busy[i] && cfg_prio[i*PRIO_W +: PRIO_W] > top)
        top = cfg_prio[i*PRIO_W +: PRIO_W];
    for (int k = 0; k < PORTS; k++) begin
      int j;
      j = int'(ptr) + k;
      if (j >= PORTS) j = j - PORTS;
      if (!found && busy[j] && cfg_prio[j*PRIO_W +: PRIO_W] == top) begin
        found = 1'b1;
        win   = PW'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= '0;
      wr        <= '0;
      ptr       <= '0;
      cmd_valid <= 1'b0;
      cmd_port  <= '0;
      cmd_write <= 1'b0;
      cmd_addr  <= '0;
      cmd_last  <= 1'b0;
      for (int i = 0; i < PORTS; i++) begin
        rem[i]  <= '0;
        addr[i] <= '0;
        dfc[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < PORTS; i++) begin
        if (req_valid[i] && !busy[i]) begin
          busy[i] <= 1'b1;
          wr[i]   <= req_write[i];
          addr[i] <= req_addr[i*ADDR_W +: ADDR_W];
          rem[i]  <= (req_len[i*LEN_W +: LEN_W] == '0) ? LEN_W'(1) : req_len[i*LEN_W +: LEN_W];
        end
      end

      if (done) begin
        cmd_valid      <= 1'b0;
        rem[cmd_port]  <= rem[cmd_port] - 1'b1;
        addr[cmd_port] <= addr[cmd_port] + ADDR_W'(BURST_BYTES);
        if (rem[cmd_port] == LEN_W'(1)) begin
          busy[cmd_port] <= 1'b0;
          dfc[cmd_port]  <= '0;
          ptr            <= nxt(cmd_port);
        end else begin
          dfc[cmd_port] <= dfc[cmd_port] - DEF_W'(1);
          if (dfc[cmd_port] == DEF_W'(1)) ptr <= nxt(cmd_port);
        end
      end

      if (take) begin
        cmd_valid <= 1'b1;
        cmd_port  <= win;
        cmd_write <= wr[win];
        cmd_addr  <= addr[win];
        cmd_last  <= (rem[win] == LEN_W'(1));
        if (dfc[win] <= 0)
          dfc[win] <= dfc[win] + $signed({2'b00, w_eff});
      end
    end
  end
endmodule

// File: rtl/burst_arbiter_checker.sv
module burst_arbiter_checker #(
  parameter int PORTS  = 6,
  parameter int ADDR_W = 32,
  parameter int PRIO_W = 2,
  localparam int PW    = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [PORTS-1:0]        req_valid,
  input logic [PORTS-1:0]        req_ready,
  input logic [PORTS*PRIO_W-1:0] cfg_prio,
  input logic                    cmd_valid,
  input logic                    cmd_ready,
  input logic [PW-1:0]           cmd_port,
  input logic                    cmd_write,
  input logic [ADDR_W-1:0]       cmd_addr,
  input logic                    cmd_last
);
  logic [PORTS-1:0]        prev_busy;
  logic [PORTS*PRIO_W-1:0] prev_prio;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_busy <= '0;
      prev_prio <= '0;
    end else begin
      prev_busy <= ~req_ready;
      prev_prio <= cfg_prio;
    end
  end

  always_comb
    if (!rst_n) assert_reset_idle_R1: assert (!cmd_valid && (&req_ready));

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_port) && $stable(cmd_addr)
                                && $stable(cmd_write) && $stable(cmd_last));

  assert_gap_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid);

  for (genvar j = 0; j < PORTS; j++) begin : g_port
    assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[j] && req_ready[j] |=> !req_ready[j]);

    assert_strict_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_valid) |-> !(prev_busy[j] &&
        prev_prio[j*PRIO_W +: PRIO_W] > prev_prio[int'(cmd_port)*PRIO_W +: PRIO_W]));
  end
endmodule

bind burst_arbiter burst_arbiter_checker #(.PORTS(PORTS), .ADDR_W(ADDR_W), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cfg_prio(cfg_prio), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_port(cmd_port), .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_last(cmd_last)
);

// File: tb/burst_arbiter_bench.sv
module burst_arbiter_bench;
  localparam int N = 6;
  localparam int BB = 32;

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic [N-1:0]    req_valid = '0;
  logic [N-1:0]    req_ready;
  logic [N-1:0]    req_write;
  logic [N*32-1:0] req_addr;
  logic [N*8-1:0]  req_len;
  logic [N*2-1:0]  cfg_prio;
  logic [N*4-1:0]  cfg_weight;
  logic            cmd_valid;
  logic            cmd_ready = 1;
  logic [2:0]      cmd_port;
  logic            cmd_write;
  logic [31:0]     cmd_addr;
  logic            cmd_last;

  int prio_b[N], wt_b[N], len_b[N];
  logic [31:0] addr_b[N];
  bit wr_b[N];

  always_comb
    for (int i = 0; i < N; i++) begin
      req_write[i]        = wr_b[i];
      req_addr[i*32 +: 32] = addr_b[i];
      req_len[i*8 +: 8]   = len_b[i][7:0];
      cfg_prio[i*2 +: 2]  = prio_b[i][1:0];
      cfg_weight[i*4 +: 4] = wt_b[i][3:0];
    end

  burst_arbiter u_burst_arbiter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .cfg_prio(cfg_prio), .cfg_weight(cfg_weight), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_port(cmd_port), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_last(cmd_last));

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";
  int ready_mode = 0;

  // reference model
  bit mbusy[N], mwr[N], accf[N];
  int mrem[N], mdef[N];
  logic [31:0] maddr[N];
  int mptr;
  bit mvalid, mwr_o, mlast;
  int mport;
  logic [31:0] maddr_o;
  int lp[$];
  logic [31:0] la[$];
  bit ll[$], lw[$];

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        mbusy[i] = 0; mrem[i] = 0; mdef[i] = 0; maddr[i] = 0; mwr[i] = 0; accf[i] = 0;
      end
      mptr = 0; mvalid = 0; mport = 0; maddr_o = 0; mwr_o = 0; mlast = 0;
    end else begin
      int top, w, e;
      bit fnd, hs;
      hs = mvalid && cmd_ready;
      top = 0; fnd = 0; w = 0;
      for (int i = 0; i < N; i++) if (mbusy[i] && prio_b[i] > top) top = prio_b[i];
      for (int k = 0; k < N; k++) begin
        int j;
        j = (mptr + k) % N;
        if (!fnd && mbusy[j] && prio_b[j] == top) begin fnd = 1; w = j; end
      end
      for (int i = 0; i < N; i++)
        if (req_valid[i] && !mbusy[i]) begin
          mbusy[i] = 1; mwr[i] = wr_b[i]; maddr[i] = addr_b[i];
          mrem[i] = (len_b[i] == 0) ? 1 : len_b[i];
          accf[i] = 1;
        end
      if (hs) begin
        int p;
        p = mport;
        lp.push_back(p); la.push_back(maddr_o); ll.push_back(mlast); lw.push_back(mwr_o);
        maddr[p] = maddr[p] + BB;
        if (mrem[p] == 1) begin
          mbusy[p] = 0; mdef[p] = 0; mptr = (p + 1) % N; mrem[p] = 0;
        end else begin
          mrem[p]--;
          if (mdef[p] == 1) mptr = (p + 1) % N;
          mdef[p]--;
        end
        mvalid = 0;
      end else if (!mvalid && fnd) begin
        mvalid = 1; mport = w; maddr_o = maddr[w]; mwr_o = mwr[w]; mlast = (mrem[w] == 1);
        e = (wt_b[w] == 0) ? 1 : wt_b[w];
        if (mdef[w] <= 0) mdef[w] += e;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(cmd_valid === mvalid, tag, cmd_valid, mvalid);
      if (mvalid && cmd_valid) begin
        chk(int'(cmd_port) == mport, tag, cmd_port, mport);
        chk(cmd_addr === maddr_o, tag, cmd_addr, maddr_o);
        chk(cmd_write === mwr_o && cmd_last === mlast, tag, {cmd_write, cmd_last}, {mwr_o, mlast});
      end
      for (int i = 0; i < N; i++)
        if (req_ready[i] !== !mbusy[i]) chk(0, "R2", req_ready[i], !mbusy[i]);
    end
    for (int i = 0; i < N; i++) if (accf[i]) begin req_valid[i] = 0; accf[i] = 0; end
    cmd_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 2) ? 1'b0 : 1'($urandom % 2);
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic post(int p, bit w, logic [31:0] a, int len);
    while (req_valid[p] || mbusy[p]) @(negedge clk);
    #1;
    wr_b[p] = w; addr_b[p] = a; len_b[p] = len; req_valid[p] = 1;
  endtask

  task automatic drain();
    bit any;
    do begin
      @(negedge clk);
      any = mvalid || (|req_valid);
      for (int i = 0; i < N; i++) any |= mbusy[i];
    end while (any);
    #1;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin prio_b[i] = 0; wt_b[i] = 1; len_b[i] = 0; addr_b[i] = 0; wr_b[i] = 0; end
    repeat (3) @(negedge clk);
    chk(cmd_valid === 0 && req_ready === '1, "R1", {cmd_valid, req_ready}, 7'h3f);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_valid === 0 && req_ready === '1, "R1", {cmd_valid, req_ready}, 7'h3f);

    // R3 splitting and R2 busy
    tag = "R3"; lp.delete(); la.delete(); ll.delete(); lw.delete();
    post(2, 1, 32'h1000, 3);
    @(negedge clk);
    chk(req_ready[2] == 0, "R2", req_ready[2], 0);
    drain();
    chk(lp.size() == 3, "R3", lp.size(), 3);
    if (lp.size() == 3) begin
      chk(la[0] == 32'h1000 && la[1] == 32'h1020 && la[2] == 32'h1040, "R3", la[2], 32'h1040);
      chk(!ll[0] && !ll[1] && ll[2] && lw[0] && lw[2], "R3", {ll[0], ll[1], ll[2]}, 3'b001);
    end
    lp.delete(); la.delete(); ll.delete(); lw.delete();
    post(5, 0, 32'h40, 0);
    drain();
    chk(lp.size() == 1 && ll[0] && !lw[0], "R3", lp.size(), 1);

    // R6 hold under stall
    tag = "R6"; ready_mode = 2;
    post(1, 0, 32'h2000, 2);
    repeat (3) @(negedge clk);
    begin
      logic [31:0] a0;
      a0 = cmd_addr;
      repeat (4) @(negedge clk);
      chk(cmd_valid && cmd_addr == a0 && cmd_port == 1, "R6", cmd_addr, a0);
      chk(req_ready[1] == 0, "R2", req_ready[1], 0);
    end
    ready_mode = 0;
    drain();

    // R4 strict level
    tag = "R4"; lp.delete(); la.delete(); ll.delete(); lw.delete();
    prio_b[0] = 1; prio_b[3] = 2;
    post(0, 0, 32'h0, 4); post(3, 0, 32'h8000, 4);
    drain();
    begin
      int c3;
      c3 = 0;
      for (int k = 0; k < 4 && k < lp.size(); k++) if (lp[k] == 3) c3++;
      chk(c3 == 4, "R4", c3, 4);
    end
    prio_b[0] = 0; prio_b[3] = 0;

    // R5 weighted share
    tag = "R5"; lp.delete(); la.delete(); ll.delete(); lw.delete();
    wt_b[0] = 3; wt_b[1] = 1;
    @(negedge clk); #1;
    wr_b[0] = 0; addr_b[0] = 0; len_b[0] = 12; wr_b[1] = 1; addr_b[1] = 32'h4000; len_b[1] = 12;
    req_valid[0] = 1; req_valid[1] = 1;
    drain();
    begin
      int c0;
      c0 = 0;
      for (int k = 0; k < 8 && k < lp.size(); k++) if (lp[k] == 0) c0++;
      chk(c0 == 6, "R5", c0, 6);
    end
    wt_b[0] = 0; wt_b[1] = 2;
    post(0, 0, 32'h100, 4); post(1, 0, 32'h200, 4);
    drain();

    // R8 credit cleared when idle
    tag = "R8";
    wt_b[0] = 4; wt_b[1] = 4;
    post(0, 0, 32'h300, 1);
    drain();
    post(1, 0, 32'h400, 5); post(0, 0, 32'h500, 5);
    drain();

    // R7 live level change
    tag = "R7"; lp.delete(); la.delete(); ll.delete(); lw.delete();
    wt_b[0] = 1; wt_b[1] = 1;
    @(negedge clk); #1;
    len_b[0] = 6; len_b[1] = 6; addr_b[0] = 0; addr_b[1] = 32'h900;
    req_valid[0] = 1; req_valid[1] = 1;
    while (lp.size() < 2) @(negedge clk);
    #1;
    begin
      int c0, c1, d0;
      c0 = 0;
      foreach (lp[k]) if (lp[k] == 0) c0++;
      prio_b[1] = 3;
      while (mbusy[1]) @(negedge clk);
      d0 = 0; c1 = 0;
      foreach (lp[k]) if (lp[k] == 0) d0++;
      chk(d0 <= c0 + 1, "R7", d0, c0 + 1);
    end
    drain();
    prio_b[1] = 0;

    // concurrent mix under random stalls
    tag = "R9"; ready_mode = 1;
    for (int it = 0; it < 3000; it++) begin
      int p;
      @(negedge clk); #1;
      p = $urandom % N;
      if (!mbusy[p] && !req_valid[p] && ($urandom % 3 == 0)) begin
        wr_b[p] = 1'($urandom); addr_b[p] = $urandom & 32'hffff_ffe0; len_b[p] = $urandom % 7;
        req_valid[p] = 1;
      end
      if ($urandom % 17 == 0) prio_b[$urandom % N] = $urandom % 4;
      if ($urandom % 13 == 0) wt_b[$urandom % N] = $urandom % 16;
    end
    ready_mode = 0;
    drain();
    chk(cmd_valid == 0 && req_ready === '1, "R9", {cmd_valid, req_ready}, 7'h3f);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule